// File: doc/BRIEF.md
# Memory Record Buffer Controller

This block records a stream of 64-bit words into a bounded region of external memory. Software sets the region's first byte address and its length in bytes through a small register port. The block then takes words from a valid/ready input and issues one write at a time on a word-addressed memory port that uses a request/acknowledge handshake. A counter tracks how many bytes the memory has acknowledged so far. Software can read this fullness count at any time.

Back-pressure rules on the input: a word moves only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low while a memory write is outstanding. It is also low once the acknowledged byte count has reached the programmed size, and while a restart waits for an in-flight write. When the region is full, words are never dropped. They wait upstream until software issues a restart. A restart sets the write position back to the base address and clears the count.

On the memory port, `mem_req` rises in the cycle after a word is taken. `mem_addr` and `mem_wdata` do not change until a cycle in which `mem_ack` is high. The count advances only on that acknowledge.

Top module: `rec_buf_ctrl`

## Requirements
- R1: After reset, the base and size registers read 0, the fullness count reads 0, `mem_req` is low and `in_ready` is low, because a size of 0 means the region is already full.
- R2: Register select 0 holds the base byte address and select 1 holds the size in bytes. The three lowest bits of each are ignored on write and read back as zero.
- R3: The n-th word accepted after a restart is written at word address (base/8 + n), counting from n = 0, with the word as data. While the write waits for `mem_ack`, `mem_req`, `mem_addr` and `mem_wdata` hold their values.
- R4: The fullness count grows by 8 bytes only in a cycle where `mem_req` and `mem_ack` are both high. A write that has not been acknowledged is not counted.
- R5: At most one write is outstanding. `in_ready` is low in every cycle in which `mem_req` is high.
- R6: Once the fullness count equals the programmed size, `in_ready` stays low and no further write is issued. Extra input words are neither taken nor lost.
- R7: Writing select 2 with bit 0 set is a restart. When no write is in flight and no word is taken in that cycle, the count reads 0 from the next cycle, and the next word goes to the base word address.
- R8: A restart issued while a write is in flight, in the same cycle a word is taken, or in the same cycle as the acknowledge, is delayed. The in-flight write finishes at its original address, `in_ready` stays low until the acknowledge, and the count then reads 0.
- R9: Select 3 returns the fullness count in bytes and select 2 reads as 0. Reads are combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 base, 1 size, 2 control, 3 fullness) |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data for `reg_addr` |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take a word |
| in_data | input | DATA_W | Input word |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | ADDR_W-3 | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory write acknowledge |

## Verification
The case that needs the most care is a restart landing in the same cycle as the memory acknowledge, and next to it a restart landing while a write is held without acknowledge. The bench holds back the memory model's acknowledge and then releases it so that the acknowledge meets the restart strobe on the same clock edge. It then checks three things: the held write went to its original address, the count reads zero afterwards, and the next word is written at the base. In the held case it also checks that the count keeps its old value and that `in_ready` stays low until the acknowledge arrives.

// File: rtl/rec_pkg.sv
package rec_pkg;
  typedef enum logic [1:0] {
    RG_BASE = 2'd0,
    RG_SIZE = 2'd1,
    RG_CTRL = 2'd2,
    RG_FILL = 2'd3
  } rg_sel_e;
endpackage

// File: rtl/rec_regs.sv
module rec_regs
  import rec_pkg::*;
#(
  parameter int AW  = 32,
  parameter int LSB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  input  logic [AW-LSB-1:0] fill_w,
  output logic [AW-LSB-1:0] base_w,
  output logic [AW-LSB-1:0] size_w,
  output logic          restart_stb,
  output logic [AW-1:0] reg_rdata
);
  rg_sel_e sel;
  logic    wdata_unused;

  assign sel          = rg_sel_e'(reg_addr);
  assign wdata_unused = ^reg_wdata[LSB-1:1];

  // Only the word-granular part of base and size is stored.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_w <= '0;
      size_w <= '0;
    end else if (reg_we) begin
      case (sel)
        RG_BASE: base_w <= reg_wdata[AW-1:LSB];
        RG_SIZE: size_w <= reg_wdata[AW-1:LSB];
        default: ;
      endcase
    end
  end

  assign restart_stb = reg_we && (sel == RG_CTRL) && reg_wdata[0];

  always_comb begin
    case (sel)
      RG_BASE: reg_rdata = {base_w, {LSB{1'b0}}};
      RG_SIZE: reg_rdata = {size_w, {LSB{1'b0}}};
      RG_FILL: reg_rdata = {fill_w, {LSB{1'b0}}};
      default: reg_rdata = '0;
    endcase
  end

  // R2: configuration only moves on a register write
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ($stable(base_w) && $stable(size_w)));
endmodule

// File: rtl/rec_fill.sv
module rec_fill #(
  parameter int HW = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] size_w,
  input  logic          restart_stb,
  input  logic          accept,
  input  logic          wr_done,
  input  logic          busy,
  output logic [HW-1:0] fill_w,
  output logic          full,
  output logic          pend
);
  logic defer;

  // A restart must wait if a write is in flight or starts this cycle.
  assign defer = busy || accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_w <= '0;
      pend   <= 1'b0;
    end else if (wr_done) begin
      pend   <= 1'b0;
      fill_w <= (pend || restart_stb) ? '0 : fill_w + 1'b1;
    end else if (restart_stb) begin
      if (defer) pend   <= 1'b1;
      else       fill_w <= '0;
    end
  end

  assign full = (fill_w >= size_w);

  // R4: the count moves only on an acknowledge (or clears)
  p_fill_on_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_done |=> ((fill_w == $past(fill_w)) || (fill_w == '0)));
  // R7: an idle restart clears at once
  p_restart_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_stb && !busy && !accept) |=> (fill_w == '0));
  // R8: a deferred restart exists only with a write in flight
  p_pend_inflight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> busy);
  // R8: the deferred restart lands on the acknowledge
  p_pend_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && wr_done) |=> (fill_w == '0));
endmodule

// File: rtl/rec_wport.sv
module rec_wport #(
  parameter int HW = 29,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [HW-1:0] base_w,
  input  logic [HW-1:0] fill_w,
  input  logic          full,
  input  logic          pend,
  input  logic          mem_ack,
  output logic          in_ready,
  output logic          accept,
  output logic          mem_req,
  output logic [HW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  assign in_ready = !mem_req && !full && !pend;
  assign accept   = in_valid && in_ready;

  // Holding register: one word in flight, held until acknowledged.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (accept) begin
      mem_req   <= 1'b1;
      mem_addr  <= base_w + fill_w;
      mem_wdata <= in_data;
    end else if (mem_ack) begin
      mem_req   <= 1'b0;
    end
  end

  // R3: request and its payload hold until acknowledged
  p_req_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));
  // R5: never ready while a write is outstanding
  p_single_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready);
endmodule

// File: rtl/rec_buf_ctrl.sv
module rec_buf_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                reg_we,
  input  logic [1:0]                          reg_addr,
  input  logic [ADDR_W-1:0]                   reg_wdata,
  output logic [ADDR_W-1:0]                   reg_rdata,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [DATA_W-1:0]                   in_data,
  output logic                                mem_req,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]  mem_addr,
  output logic [DATA_W-1:0]                   mem_wdata,
  input  logic                                mem_ack
);
  localparam int LSB = $clog2(DATA_W/8);
  localparam int HW  = ADDR_W - LSB;

  logic [HW-1:0] base_w, size_w, fill_w;
  logic          restart_stb, accept, full, pend, wr_done;

  assign wr_done = mem_req && mem_ack;

  rec_regs #(.AW(ADDR_W), .LSB(LSB)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .fill_w     (fill_w),
    .base_w     (base_w),
    .size_w     (size_w),
    .restart_stb(restart_stb),
    .reg_rdata  (reg_rdata)
  );

  rec_fill #(.HW(HW)) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .size_w     (size_w),
    .restart_stb(restart_stb),
    .accept     (accept),
    .wr_done    (wr_done),
    .busy       (mem_req),
    .fill_w     (fill_w),
    .full       (full),
    .pend       (pend)
  );

  rec_wport #(.HW(HW), .DW(DATA_W)) u_wport (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .base_w   (base_w),
    .fill_w   (fill_w),
    .full     (full),
    .pend     (pend),
    .mem_ack  (mem_ack),
    .in_ready (in_ready),
    .accept   (accept),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
  );

  // R6: a taken word always fits inside the region
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> ({1'b0, fill_w} < {1'b0, size_w}));
  // R6: a full region raises no new request
  p_full_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !mem_req) |=> !mem_req);
endmodule

// File: tb/sim_rec_buf_ctrl.sv
module sim_rec_buf_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = 64'd0;
  logic        mem_req;
  logic [28:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_ack = 1'b0;

  always #2 clk = ~clk;

  rec_buf_ctrl u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [63:0] q_src[$];
  logic [28:0] log_a[$];
  logic [63:0] log_d[$];
  int  mem_delay = 1, wait_cnt = 0, gap_pct = 0;
  bit  hold_ack = 0, src_en = 0, fire_pend = 0, prev_hold = 0;
  int  viol_r3 = 0, viol_r5 = 0;
  logic [28:0] prev_a;
  logic [63:0] prev_d;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // memory model and port monitors
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 0; wait_cnt = 0; prev_hold = 0;
    end else begin
      if (prev_hold && (!mem_req || mem_addr != prev_a || mem_wdata != prev_d)) viol_r3++;
      if (mem_req && in_ready) viol_r5++;
      if (mem_ack) begin
        mem_ack = 0; wait_cnt = 0;
      end else if (mem_req && !hold_ack) begin
        if (wait_cnt >= mem_delay) begin
          mem_ack = 1;
          log_a.push_back(mem_addr);
          log_d.push_back(mem_wdata);
        end else wait_cnt++;
      end
      prev_hold = mem_req && !mem_ack;
      prev_a = mem_addr;
      prev_d = mem_wdata;
    end
  end

  // stream source: valid held until taken
  always @(negedge clk) begin
    if (!rst_n) begin
      in_valid = 0; fire_pend = 0;
    end else begin
      if (fire_pend && q_src.size() > 0) void'(q_src.pop_front());
      if (!src_en) in_valid = 0;
      else if (!in_valid || fire_pend) begin
        if (q_src.size() > 0 && ($urandom % 100) >= gap_pct) begin
          in_valid = 1; in_data = q_src[0];
        end else in_valid = 0;
      end
      fire_pend = in_valid && in_ready;
    end
  end

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; #1;
    d = reg_rdata;
  endtask

  task automatic wait_logs(input int n);
    int t = 0;
    while (log_a.size() < n && t < 3000) begin @(negedge clk); t++; end
  endtask

  task automatic wait_req();
    int t = 0;
    @(negedge clk);
    while (!mem_req && t < 300) begin @(negedge clk); t++; end
  endtask

  task automatic setup(input logic [31:0] base, input logic [31:0] size);
    src_en = 0;
    reg_wr(2'd2, 32'd1);
    reg_wr(2'd0, base);
    reg_wr(2'd1, size);
    log_a.delete(); log_d.delete(); q_src.delete();
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic run_round(input logic [31:0] base_raw, input logic [31:0] size_raw,
                           input int extra);
    int nw = int'(size_raw >> 3);
    logic [28:0] bw = base_raw[31:3];
    logic [63:0] exp_d[$];
    logic [31:0] d;
    setup(base_raw, size_raw);
    for (int i = 0; i < nw + extra; i++) begin
      logic [63:0] w = rnd64();
      q_src.push_back(w); exp_d.push_back(w);
    end
    src_en = 1;
    wait_logs(nw);
    repeat (20) @(negedge clk);
    chk(log_a.size() == nw, "R6", "write count", 64'(log_a.size()), 64'(nw));
    for (int i = 0; i < nw && i < log_a.size(); i++) begin
      chk(log_a[i] == bw + 29'(i), "R3", "write address", 64'(log_a[i]), 64'(bw + 29'(i)));
      chk(log_d[i] == exp_d[i], "R3", "write data", log_d[i], exp_d[i]);
    end
    reg_rd(2'd3, d);
    chk(d == 32'(nw * 8), "R4", "fullness bytes", 64'(d), 64'(nw * 8));
    @(negedge clk);
    chk(!in_ready && !mem_req, "R6", "stalled when full", {in_ready, mem_req}, 0);
    chk(q_src.size() == extra, "R6", "words left upstream", 64'(q_src.size()), 64'(extra));
    src_en = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(!in_ready, "R1", "in_ready after reset", in_ready, 0);
    chk(!mem_req, "R1", "mem_req after reset", mem_req, 0);
    reg_rd(2'd3, d); chk(d == 0, "R1", "fullness after reset", d, 0);
    reg_rd(2'd0, d); chk(d == 0, "R1", "base after reset", d, 0);
    reg_rd(2'd1, d); chk(d == 0, "R1", "size after reset", d, 0);

    // R2: alignment on register write; R9: control reads zero
    reg_wr(2'd0, 32'h1234_5677);
    reg_rd(2'd0, d); chk(d == 32'h1234_5670, "R2", "base readback", d, 32'h1234_5670);
    reg_wr(2'd1, 32'h0000_0fff);
    reg_rd(2'd1, d); chk(d == 32'h0000_0ff8, "R2", "size readback", d, 32'h0ff8);
    reg_rd(2'd2, d); chk(d == 0, "R9", "control reads zero", d, 0);

    // directed: back-to-back, fast memory
    mem_delay = 0; gap_pct = 0;
    run_round(32'h0000_0100, 32'd40, 2);
    // R7: idle restart clears and reopens
    reg_wr(2'd2, 32'd1);
    reg_rd(2'd3, d); chk(d == 0, "R7", "fullness after restart", d, 0);
    @(negedge clk); chk(in_ready, "R7", "ready after restart", in_ready, 1);
    // R2: unaligned base and size in use
    mem_delay = 2; gap_pct = 50;
    run_round(32'h0000_2003, 32'd53, 3);
    // single-word region
    mem_delay = 1; gap_pct = 20;
    run_round(32'h0000_0808, 32'd8, 1);
    // random rounds
    for (int r = 0; r < 6; r++) begin
      mem_delay = int'($urandom % 4);
      gap_pct   = int'($urandom % 70);
      run_round(($urandom % 65536) << 3, (1 + $urandom % 10) << 3, 1 + int'($urandom % 3));
    end

    // R8: restart while a write is held
    mem_delay = 1; gap_pct = 0; hold_ack = 0;
    setup(32'h400, 32'd64);
    q_src.push_back(rnd64()); q_src.push_back(rnd64());
    src_en = 1;
    wait_logs(2);
    repeat (3) @(negedge clk);
    @(posedge clk); #1 hold_ack = 1;
    q_src.push_back(rnd64()); q_src.push_back(rnd64());
    wait_req();
    reg_wr(2'd2, 32'd1);
    repeat (3) @(negedge clk);
    chk(!in_ready, "R8", "ready low while restart waits", in_ready, 0);
    chk(mem_req, "R8", "write still held", mem_req, 1);
    reg_rd(2'd3, d); chk(d == 16, "R8", "count kept before ack", d, 16);
    @(posedge clk); #1 hold_ack = 0;
    wait_logs(4);
    repeat (5) @(negedge clk);
    chk(log_a.size() == 4, "R8", "write count", 64'(log_a.size()), 4);
    if (log_a.size() == 4) begin
      chk(log_a[2] == 29'h82, "R8", "held write address", 64'(log_a[2]), 64'h82);
      chk(log_a[3] == 29'h80, "R8", "write after restart", 64'(log_a[3]), 64'h80);
    end
    reg_rd(2'd3, d); chk(d == 8, "R8", "count after restart", d, 8);
    src_en = 0;

    // R8: restart in the same cycle as the acknowledge
    setup(32'h800, 32'd64);
    q_src.push_back(rnd64());
    src_en = 1;
    wait_logs(1);
    repeat (3) @(negedge clk);
    @(posedge clk); #1 hold_ack = 1;
    q_src.push_back(rnd64());
    wait_req();
    @(posedge clk); #1;
    mem_delay = 0; hold_ack = 0;
    reg_we = 1; reg_addr = 2'd2; reg_wdata = 32'd1;
    @(posedge clk); #1;
    reg_we = 0;
    @(posedge clk); #1;
    src_en = 0;
    repeat (2) @(negedge clk);
    reg_rd(2'd3, d); chk(d == 0, "R8", "count after ack+restart", d, 0);
    chk(log_a.size() == 2, "R8", "write count", 64'(log_a.size()), 2);
    if (log_a.size() == 2)
      chk(log_a[1] == 29'h101, "R8", "coincident write address", 64'(log_a[1]), 64'h101);
    @(negedge clk); chk(in_ready, "R7", "ready after coincident restart", in_ready, 1);

    chk(viol_r3 == 0, "R3", "request held stable", 64'(viol_r3), 0);
    chk(viol_r5 == 0, "R5", "ready low while busy", 64'(viol_r5), 0);
    finish_run();
  end
endmodule